// File: doc/BRIEF.md
# Compare, Population-Count and Byte-Add Execution Unit

This unit executes a small group of single-cycle integer operations on two 64-bit operands. It takes a 32-bit instruction word together with the values of its two source registers. It decodes the word and computes the selected result. One clock edge later it presents a decode-hit flag, a register-file write enable, the destination register index and the 64-bit result.

The operations are an unsigned byte-wide add, the low half of a 64 by 64 multiply, and a population count over either the low 32 bits or all 64 bits. There are also equality and inequality tests that write 0 or 1. These tests come in a register-register form and in a form that compares against a 10-bit signed immediate. A single function bit picks between the two widths of the count and between the two senses of the compare. The register file, hazard handling and multiplier pipelining sit outside the unit.

Top module: `cmp_pop_alu`

## Requirements
- R1: The outputs are registered. The edge that samples `valid_in` high with a matching word loads `hit_o` = 1, `dest_o` and `result_o`. The edge that samples `valid_in` low clears `hit_o` and `wr_en_o`. After reset all outputs are zero.
- R2: Byte add applies when bits 31:26 = 011100, bits 10:6 = 0 and bits 5:0 = 101000. The result is (rs+rt) mod 256, zero-extended to 64 bits, and it is written to rd in bits 15:11.
- R3: Multiply applies when bits 31:26 = 011100, bits 10:6 = 0 and bits 5:0 = 000011. It writes the low 64 bits of rs*rt to rd.
- R4: Population count applies when bits 31:26 = 011100, rt field 20:16 = 0, bits 10:6 = 0 and bits 5:1 = 10110. It writes to rd the number of set bits of rs. With bit 0 = 1 all 64 bits are counted; with bit 0 = 0 only bits 31:0 are counted.
- R5: The register compare applies when bits 31:26 = 011100, bits 10:6 = 0 and bits 5:1 = 10101. It writes 1 to rd when bit 0 = 0 and rs == rt, or when bit 0 = 1 and rs != rt. Otherwise it writes 0.
- R6: The immediate compare applies when bits 31:26 = 011100 and bits 5:1 = 10111. Bits 15:6 hold a signed immediate that is sign-extended to 64 bits and compared with rs, using bit 0 for the sense as in R5. The result goes to the register named by bits 20:16.
- R7: When the destination index is 0, `wr_en_o` stays 0 while `hit_o`, `dest_o` and `result_o` still follow R1.
- R8: A word that matches no operation, including any word whose bits 31:26 differ from 011100, gives `hit_o` = 0, `wr_en_o` = 0 and `result_o` = 0.
- R9: A register-form word with bits 10:6 non-zero, or a count word with a non-zero rt field, is treated as unmatched under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Instruction strobe |
| instr_in | input | 32 | Instruction word |
| rs_val | input | 64 | First operand value |
| rt_val | input | 64 | Second operand value |
| hit_o | output | 1 | Word was decoded as one of the operations |
| wr_en_o | output | 1 | Register-file write enable |
| dest_o | output | 5 | Destination register index |
| result_o | output | 64 | Operation result |

## Verification
Each operation is swept with pseudo-random operand pairs and with edge values: all-zero, all-ones, a single bit, and values whose upper 32 bits differ from their lower 32 bits. The edge values tell the 32-bit count apart from the 64-bit one and expose carries out of the byte add. Compares are driven with equal pairs, with pairs that differ in one bit, and with immediates from −512 to 511 against both sign-extended and zero-extended operands. These patterns separate the two senses and catch a missing sign extension. Destination 0, non-zero reserved fields, a foreign major opcode and idle cycles show that the unit withholds writes and hits as required.

// File: rtl/cmp_pop_alu_pkg.sv
package cmp_pop_alu_pkg;
  localparam int XLEN  = 64;
  localparam int IMMW  = 10;
  localparam int REGW  = 5;
  localparam int CNTW  = $clog2(XLEN) + 1;

  localparam logic [5:0] MAJOR_OP   = 6'b011100;
  localparam logic [5:0] FN_BYTEADD = 6'b101000;
  localparam logic [5:0] FN_MULLO   = 6'b000011;
  localparam logic [4:0] FN5_POP    = 5'b10110;
  localparam logic [4:0] FN5_CMPR   = 5'b10101;
  localparam logic [4:0] FN5_CMPI   = 5'b10111;

  typedef enum logic [2:0] {
    OP_NONE, OP_BYTEADD, OP_MULLO, OP_POP, OP_CMPR, OP_CMPI
  } alu_op_e;

  function automatic logic [XLEN-1:0] f_byteadd(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [XLEN-1:0] s;
    s = a + b;
    return {{(XLEN-8){1'b0}}, s[7:0]};
  endfunction

  function automatic logic [XLEN-1:0] f_popcount(logic [XLEN-1:0] v, logic full);
    logic [CNTW-1:0] c;
    c = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (full || i < XLEN/2) c = c + CNTW'(v[i]);
    end
    return XLEN'(c);
  endfunction

  function automatic logic [XLEN-1:0] f_sext_imm(logic [IMMW-1:0] imm);
    return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  endfunction
endpackage

// File: rtl/cmp_pop_alu_decode.sv
module cmp_pop_alu_decode
  import cmp_pop_alu_pkg::*;
(
  input  logic [31:0]     instr,
  output alu_op_e         op_o,
  output logic            sel_o,
  output logic [REGW-1:0] dest_o,
  output logic [IMMW-1:0] imm_o
);
  logic            major_ok;
  logic            shamt_zero;
  logic            rt_zero;
  logic [4:0]      fn5;
  logic [5:0]      fn6;

  assign major_ok   = (instr[31:26] == MAJOR_OP);
  assign shamt_zero = (instr[10:6] == 5'd0);
  assign rt_zero    = (instr[20:16] == 5'd0);
  assign fn6        = instr[5:0];
  assign fn5        = instr[5:1];
  assign sel_o      = instr[0];
  assign imm_o      = instr[15:6];

  always_comb begin
    op_o = OP_NONE;
    if (major_ok) begin
      if (fn5 == FN5_CMPI)                              op_o = OP_CMPI;
      else if (shamt_zero && fn6 == FN_BYTEADD)         op_o = OP_BYTEADD;
      else if (shamt_zero && fn6 == FN_MULLO)           op_o = OP_MULLO;
      else if (shamt_zero && rt_zero && fn5 == FN5_POP) op_o = OP_POP;
      else if (shamt_zero && fn5 == FN5_CMPR)           op_o = OP_CMPR;
    end
  end

  assign dest_o = (op_o == OP_CMPI) ? instr[20:16] : instr[15:11];
endmodule

// File: rtl/cmp_pop_alu_exec.sv
module cmp_pop_alu_exec
  import cmp_pop_alu_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic            sel_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] imm_ext;
  logic            eq_reg;
  logic            eq_imm;

  assign imm_ext = f_sext_imm(imm_i);
  assign eq_reg  = (a_i == b_i);
  assign eq_imm  = (a_i == imm_ext);

  always_comb begin
    unique case (op_i)
      OP_BYTEADD: res_o = f_byteadd(a_i, b_i);
      OP_MULLO:   res_o = a_i * b_i;
      OP_POP:     res_o = f_popcount(a_i, sel_i);
      OP_CMPR:    res_o = XLEN'(eq_reg ^ sel_i);
      OP_CMPI:    res_o = XLEN'(eq_imm ^ sel_i);
      default:    res_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_pop_alu.sv
module cmp_pop_alu
  import cmp_pop_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_in,
  input  logic [31:0]     instr_in,
  input  logic [63:0]     rs_val,
  input  logic [63:0]     rt_val,
  output logic            hit_o,
  output logic            wr_en_o,
  output logic [4:0]      dest_o,
  output logic [63:0]     result_o
);
  alu_op_e         dec_op;
  logic            dec_sel;
  logic [REGW-1:0] dec_dest;
  logic [IMMW-1:0] dec_imm;
  logic [XLEN-1:0] exec_res;
  logic            dec_hit;
  logic            dest_nonzero;

  cmp_pop_alu_decode u_dec (
    .instr (instr_in),
    .op_o  (dec_op),
    .sel_o (dec_sel),
    .dest_o(dec_dest),
    .imm_o (dec_imm)
  );

  cmp_pop_alu_exec u_exe (
    .op_i (dec_op),
    .sel_i(dec_sel),
    .imm_i(dec_imm),
    .a_i  (rs_val),
    .b_i  (rt_val),
    .res_o(exec_res)
  );

  assign dec_hit      = (dec_op != OP_NONE);
  assign dest_nonzero = (dec_dest != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o    <= 1'b0;
      wr_en_o  <= 1'b0;
      dest_o   <= '0;
      result_o <= '0;
    end else begin
      hit_o   <= valid_in && dec_hit;
      wr_en_o <= valid_in && dec_hit && dest_nonzero;
      if (valid_in) begin
        dest_o   <= dec_dest;
        result_o <= exec_res;
      end
    end
  end

  p_wen_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> hit_o);
  p_no_zero_dest_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (dest_o != 5'd0));
  p_idle_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!hit_o && !wr_en_o));
  p_result_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dec_hit) |=> (hit_o && result_o == $past(exec_res)));
  p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_BYTEADD) |-> (exec_res[63:8] == 56'd0));
  p_pop_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_POP) |-> (exec_res <= (dec_sel ? 64'd64 : 64'd32)));
  p_cmp_boolean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_CMPR || dec_op == OP_CMPI) |-> (exec_res[63:1] == 63'd0));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !dec_hit) |=> (!hit_o && result_o == 64'd0));
endmodule

// File: tb/cmp_pop_alu_bench.sv
module cmp_pop_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] instr_in = '0;
  logic [63:0] rs_val = '0, rt_val = '0;
  logic        hit_o, wr_en_o;
  logic [4:0]  dest_o;
  logic [63:0] result_o;

  int total = 0, bad = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
  bit done = 0;

  cmp_pop_alu u_cmp_pop_alu (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .instr_in(instr_in),
    .rs_val(rs_val), .rt_val(rt_val), .hit_o(hit_o), .wr_en_o(wr_en_o),
    .dest_o(dest_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] next_rand(logic [63:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] rt, logic [4:0] rd, logic [4:0] sh, logic [5:0] fn);
    return {6'b011100, 5'd3, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [4:0] rt, logic [9:0] imm, logic ne);
    return {6'b011100, 5'd4, rt, imm, 5'b10111, ne};
  endfunction

  task automatic run(string tag, logic [31:0] w, logic [63:0] a, logic [63:0] b,
                     logic ehit, logic [4:0] edest, logic [63:0] eres);
    @(negedge clk);
    valid_in = 1'b1; instr_in = w; rs_val = a; rt_val = b;
    @(negedge clk);
    valid_in = 1'b0;
    chk({tag, " hit"}, 64'(hit_o), 64'(ehit));
    chk({tag, " wen"}, 64'(wr_en_o), 64'(ehit && edest != 0));
    if (ehit) chk({tag, " dest"}, 64'(dest_o), 64'(edest));
    chk({tag, " result"}, result_o, eres);
  endtask

  function automatic logic [63:0] pick(int i);
    case (i % 6)
      0: return 64'd0;
      1: return '1;
      2: return 64'd1 << (i % 64);
      3: return 64'hFFFF_FFFF_0000_0000;
      4: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'h8000_0000_0000_00FF;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [4:0] d;
    #(CLK_PERIOD * 2 + 2);
    chk("R1 reset hit", 64'(hit_o), 0);
    chk("R1 reset wen", 64'(wr_en_o), 0);
    chk("R1 reset dest", 64'(dest_o), 0);
    chk("R1 reset result", result_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 60; i++) begin
      if (i < 12) begin a = pick(i); b = pick(i + 3); end
      else begin rng = next_rand(rng); a = rng; rng = next_rand(rng); b = rng; end
      d = 5'(i % 31 + 1);
      run("R2 byteadd", enc_r(5'd7, d, 5'd0, 6'b101000), a, b, 1, d, 64'((a[7:0] + b[7:0]) % 256));
      run("R3 mullo", enc_r(5'd7, d, 5'd0, 6'b000011), a, b, 1, d, a * b);
      run("R4 pop64", enc_r(5'd0, d, 5'd0, 6'b101101), a, b, 1, d, 64'($countones(a)));
      run("R4 pop32", enc_r(5'd0, d, 5'd0, 6'b101100), a, b, 1, d, 64'($countones(a[31:0])));
      run("R5 seq", enc_r(5'd7, d, 5'd0, 6'b101010), a, (i % 2 == 0) ? a : b, 1, d,
          64'((i % 2 == 0) || a == b));
      run("R5 sne", enc_r(5'd7, d, 5'd0, 6'b101011), a, (i % 3 == 0) ? a : (a ^ (64'd1 << (i % 64))), 1, d,
          64'(i % 3 != 0));
    end

    for (int k = -512; k < 512; k += 37) begin
      logic [9:0] imm;
      logic [63:0] sx;
      imm = 10'(k);
      sx = 64'(signed'(k));
      d = 5'((k + 512) % 31 + 1);
      run("R6 seqi match", enc_i(d, imm, 1'b0), sx, '1, 1, d, 64'd1);
      run("R6 snei match", enc_i(d, imm, 1'b1), sx, '1, 1, d, 64'd0);
      run("R6 seqi zext", enc_i(d, imm, 1'b0), {54'd0, imm}, '0, 1, d, 64'(k >= 0));
      run("R6 snei zext", enc_i(d, imm, 1'b1), {54'd0, imm}, '0, 1, d, 64'(k < 0));
    end

    run("R7 zero dest byteadd", enc_r(5'd7, 5'd0, 5'd0, 6'b101000), 64'hFF, 64'h2, 1, 5'd0, 64'h01);
    run("R7 zero dest cmpi", enc_i(5'd0, 10'd5, 1'b0), 64'd5, 0, 1, 5'd0, 64'd1);

    run("R8 bad major", {6'b000000, 26'h0000028}, 64'd1, 64'd2, 0, 5'd0, 64'd0);
    run("R8 bad funct", enc_r(5'd7, 5'd9, 5'd0, 6'b111111), 64'd1, 64'd2, 0, 5'd0, 64'd0);
    run("R9 shamt byteadd", enc_r(5'd7, 5'd9, 5'd4, 6'b101000), 64'd1, 64'd2, 0, 5'd0, 64'd0);
    run("R9 shamt seq", enc_r(5'd7, 5'd9, 5'd1, 6'b101010), 64'd1, 64'd1, 0, 5'd0, 64'd0);
    run("R9 pop rt", enc_r(5'd2, 5'd9, 5'd0, 6'b101101), '1, 64'd0, 0, 5'd0, 64'd0);

    run("R1 pre-idle", enc_r(5'd7, 5'd3, 5'd0, 6'b000011), 64'd6, 64'd7, 1, 5'd3, 64'd42);
    @(negedge clk);
    chk("R1 idle hit", 64'(hit_o), 0);
    chk("R1 idle wen", 64'(wr_en_o), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule